// File: doc/BRIEF.md
# Front-to-Back Ray Compositor with Group Termination

This block accumulates colour and opacity for a group of interleaved rays. Upstream logic sends one shaded sample per cycle. Each sample carries red, green, blue and opacity channels, the index of the ray it belongs to, flags that mark the first and last sample of that ray, and the id of the ray group. The ray index selects one of `NRAYS` accumulators. The sample is blended into that accumulator in front-to-back order, or, when the max-intensity mode is selected, the accumulator keeps the per-channel maximum. When a ray's final sample has been folded in, the finished pixel leaves the block together with its ray index and group id.

The block also decides when a group can stop early. It watches every ray's accumulated opacity against a programmable threshold. Once all rays of the current group are at or above the threshold, it sends a single termination pulse, tagged with the group id, back to the sample generator. Samples that are already on their way are still composited normally, until each ray's last sample arrives.

Top module: `fb_compositor`

## Requirements
- R1: A sample with the first flag set is combined with an all-zero accumulator, not with the ray's earlier contents. The result becomes the new state of that ray.
- R2: In blend mode (`mip_en`=0), with full scale FS = 2^CW−1 and mul(x,y) = (x·y) >> CW, the new opacity is A + mul(a_s, FS−A). Each new colour channel is C + mul(mul(c_s, a_s), FS−A). Every result saturates at FS.
- R3: In max-intensity mode (`mip_en`=1), each of the four channels of the accumulator becomes the larger of its old value and the sample value.
- R4: The ray index selects which accumulator is read and written. The state of all other rays is unchanged. A pixel reports the ray index and group id of its last sample.
- R5: `px_valid` is high for exactly the cycle after a valid sample with the last flag set. The pixel carries the updated accumulator. At all other times `px_valid` is low.
- R6: Each valid sample marks its ray as reached when the ray's new opacity is at least `op_thresh`. In the cycle after the sample that leaves all `NRAYS` rays reached, `term_req` pulses for one cycle and `term_grp` carries that sample's group id.
- R7: At most one termination pulse is sent per group. A first-flagged sample whose group id differs from the tracked group clears all reached marks, re-arms the pulse and becomes the tracked group. Samples from any other group never cause a pulse.
- R8: After a termination pulse, samples of the group keep being accumulated and keep producing pixels exactly as in R2 and R3.
- R9: A valid sample whose ray index is `NRAYS` or more is ignored: it produces no pixel and changes no ray or termination state.
- R10: After reset all accumulators, reached marks and the tracked group id (0) are cleared, and `px_valid` and `term_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mip_en | input | 1 | 1 selects max-intensity mode, 0 selects blending |
| op_thresh | input | CW | Opacity threshold for early termination |
| s_valid | input | 1 | Sample present this cycle |
| s_ray | input | RIDW | Ray index within the group |
| s_first | input | 1 | First sample of the ray |
| s_last | input | 1 | Last sample of the ray |
| s_grp | input | GW | Group id |
| s_red | input | CW | Sample red |
| s_green | input | CW | Sample green |
| s_blue | input | CW | Sample blue |
| s_alpha | input | CW | Sample opacity |
| px_valid | output | 1 | Finished pixel present |
| px_ray | output | RIDW | Ray index of the pixel |
| px_grp | output | GW | Group id of the pixel |
| px_red | output | CW | Accumulated red |
| px_green | output | CW | Accumulated green |
| px_blue | output | CW | Accumulated blue |
| px_alpha | output | CW | Accumulated opacity |
| term_req | output | 1 | Early-termination pulse |
| term_grp | output | GW | Group id of the termination |

## Verification
The hardest case to reach is the moment when the last of the nine rays crosses the threshold while earlier rays are already marked. Straight after it, further samples of the same group arrive, and they must neither repeat the pulse nor disturb the blending. A second hard case is a new group that starts while the old group's marks are still set. The stimulus reaches both with directed groups of full-opacity samples over several rounds and with back-to-back groups whose threshold is zero. It then runs seeded random groups with random lengths, thresholds, modes, idle cycles and out-of-range ray indices mixed into the stream.

// File: rtl/comp_pkg.sv
package comp_pkg;
   typedef enum logic {
      CM_BLEND = 1'b0,
      CM_MIP   = 1'b1
   } comp_mode_e;

   localparam int unsigned NCH = 4;   // channel 3 is opacity
   localparam int unsigned CH_A = 3;
endpackage

// File: rtl/comp_blend.sv
module comp_blend
   import comp_pkg::*;
#(
   parameter int unsigned CW = 16
) (
   input  comp_mode_e                mode,
   input  logic [NCH-1:0][CW-1:0]    base,
   input  logic [NCH-1:0][CW-1:0]    smp,
   output logic [NCH-1:0][CW-1:0]    res
);
   localparam logic [CW-1:0] FS = {CW{1'b1}};

   function automatic logic [CW-1:0] fx_mul(input logic [CW-1:0] x, input logic [CW-1:0] y);
      logic [2*CW-1:0] p;
      p = {{CW{1'b0}}, x} * {{CW{1'b0}}, y};
      return p[2*CW-1:CW];
   endfunction

   function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] x, input logic [CW-1:0] y);
      logic [CW:0] s;
      s = {1'b0, x} + {1'b0, y};
      return s[CW] ? FS : s[CW-1:0];
   endfunction

   logic [CW-1:0] remain;
   assign remain = FS - base[CH_A];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [CW-1:0] weighted;
      logic [CW-1:0] blended;
      if (c == CH_A) begin : g_alpha
         assign weighted = smp[c];
      end else begin : g_color
         assign weighted = fx_mul(smp[c], smp[CH_A]);
      end
      assign blended = sat_add(base[c], fx_mul(weighted, remain));
      always_comb begin
         if (mode == CM_MIP) res[c] = (smp[c] > base[c]) ? smp[c] : base[c];
         else                res[c] = blended;
      end
   end
endmodule

// File: rtl/comp_ray_bank.sv
module comp_ray_bank
   import comp_pkg::*;
#(
   parameter int unsigned NRAYS = 9,
   parameter int unsigned CW    = 16,
   parameter int unsigned RIDW  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [RIDW-1:0]           idx,
   input  logic [NCH-1:0][CW-1:0]    wr_data,
   output logic [NCH-1:0][CW-1:0]    rd_data
);
   logic [NCH-1:0][CW-1:0] slot [NRAYS];

   for (genvar i = 0; i < NRAYS; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                               slot[i] <= '0;
         else if (wr_en && idx == RIDW'(i))        slot[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NRAYS; i++)
         if (idx == RIDW'(i)) rd_data = slot[i];
   end
endmodule

// File: rtl/comp_group_term.sv
module comp_group_term #(
   parameter int unsigned NRAYS = 9,
   parameter int unsigned CW    = 16,
   parameter int unsigned RIDW  = 4,
   parameter int unsigned GW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [RIDW-1:0]  ray,
   input  logic             first,
   input  logic [GW-1:0]    grp,
   input  logic [CW-1:0]    new_alpha,
   input  logic [CW-1:0]    thresh,
   output logic             term_req,
   output logic [GW-1:0]    term_grp
);
   logic [NRAYS-1:0] reached, reached_n;
   logic             sent, sent_n;
   logic [GW-1:0]    track, track_n;
   logic             fire;

   always_comb begin
      reached_n = reached;
      sent_n    = sent;
      track_n   = track;
      fire      = 1'b0;
      if (take) begin
         if (first && grp != track) begin
            reached_n = '0;
            sent_n    = 1'b0;
            track_n   = grp;
         end
         for (int i = 0; i < NRAYS; i++)
            if (ray == RIDW'(i)) reached_n[i] = (new_alpha >= thresh);
         fire = (&reached_n) && !sent_n && (grp == track_n);
         if (fire) sent_n = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reached  <= '0;
         sent     <= 1'b0;
         track    <= '0;
         term_req <= 1'b0;
         term_grp <= '0;
      end else begin
         reached  <= reached_n;
         sent     <= sent_n;
         track    <= track_n;
         term_req <= fire;
         if (fire) term_grp <= grp;
      end
   end
endmodule

// File: rtl/fb_compositor.sv
module fb_compositor
   import comp_pkg::*;
#(
   parameter int unsigned NRAYS = 9,
   parameter int unsigned CW    = 16,
   parameter int unsigned RIDW  = 4,
   parameter int unsigned GW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mip_en,
   input  logic [CW-1:0]    op_thresh,
   input  logic             s_valid,
   input  logic [RIDW-1:0]  s_ray,
   input  logic             s_first,
   input  logic             s_last,
   input  logic [GW-1:0]    s_grp,
   input  logic [CW-1:0]    s_red,
   input  logic [CW-1:0]    s_green,
   input  logic [CW-1:0]    s_blue,
   input  logic [CW-1:0]    s_alpha,
   output logic             px_valid,
   output logic [RIDW-1:0]  px_ray,
   output logic [GW-1:0]    px_grp,
   output logic [CW-1:0]    px_red,
   output logic [CW-1:0]    px_green,
   output logic [CW-1:0]    px_blue,
   output logic [CW-1:0]    px_alpha,
   output logic             term_req,
   output logic [GW-1:0]    term_grp
);
   localparam logic [RIDW-1:0] TOP_RAY = RIDW'(NRAYS - 1);

   if (NRAYS < 2) begin : g_bad_rays
      $error("fb_compositor: NRAYS must be at least 2");
   end
   if ((1 << RIDW) < NRAYS) begin : g_bad_ridw
      $error("fb_compositor: RIDW too narrow for NRAYS");
   end
   if (CW < 8 || CW > 32) begin : g_bad_cw
      $error("fb_compositor: CW must lie in 8..32");
   end
   if (GW < 1) begin : g_bad_gw
      $error("fb_compositor: GW must be at least 1");
   end

   logic                   take;
   comp_mode_e             mode;
   logic [NCH-1:0][CW-1:0] stored, base, smp, upd;

   assign take = s_valid && (s_ray <= TOP_RAY);
   assign mode = mip_en ? CM_MIP : CM_BLEND;
   assign smp  = {s_alpha, s_blue, s_green, s_red};
   assign base = s_first ? '0 : stored;

   comp_ray_bank #(.NRAYS(NRAYS), .CW(CW), .RIDW(RIDW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (take),
      .idx     (s_ray),
      .wr_data (upd),
      .rd_data (stored)
   );

   comp_blend #(.CW(CW)) u_blend (
      .mode (mode),
      .base (base),
      .smp  (smp),
      .res  (upd)
   );

   comp_group_term #(.NRAYS(NRAYS), .CW(CW), .RIDW(RIDW), .GW(GW)) u_term (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .ray       (s_ray),
      .first     (s_first),
      .grp       (s_grp),
      .new_alpha (upd[CH_A]),
      .thresh    (op_thresh),
      .term_req  (term_req),
      .term_grp  (term_grp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         px_valid <= 1'b0;
         px_ray   <= '0;
         px_grp   <= '0;
         px_red   <= '0;
         px_green <= '0;
         px_blue  <= '0;
         px_alpha <= '0;
      end else begin
         px_valid <= take && s_last;
         if (take && s_last) begin
            px_ray   <= s_ray;
            px_grp   <= s_grp;
            px_red   <= upd[0];
            px_green <= upd[1];
            px_blue  <= upd[2];
            px_alpha <= upd[CH_A];
         end
      end
   end
endmodule

// File: rtl/comp_chk.sv
module comp_chk #(
   parameter int unsigned NRAYS = 9,
   parameter int unsigned RIDW  = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            s_valid,
   input logic [RIDW-1:0] s_ray,
   input logic            s_last,
   input logic            px_valid,
   input logic            term_req
);
   localparam logic [RIDW-1:0] TOP_RAY = RIDW'(NRAYS - 1);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R5
   pixel_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && px_valid) |-> $past(s_valid && s_last && (s_ray <= TOP_RAY)));

   // R6
   term_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && term_req) |-> $past(s_valid && (s_ray <= TOP_RAY)));

   // R7
   term_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_req |=> !term_req);

   // R9
   bad_ray_no_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && (s_ray > TOP_RAY)) |=> !px_valid);

   // R9
   bad_ray_no_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && (s_ray > TOP_RAY)) |=> !term_req);
endmodule

bind fb_compositor comp_chk #(.NRAYS(NRAYS), .RIDW(RIDW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .s_valid  (s_valid),
   .s_ray    (s_ray),
   .s_last   (s_last),
   .px_valid (px_valid),
   .term_req (term_req)
);

// File: tb/sim_fb_compositor.sv
module sim_fb_compositor;
   localparam int NR = 9;
   localparam int CW = 16;
   localparam int unsigned FS = 65535;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mip_en = 1'b0;
   logic [15:0] op_thresh = '0;
   logic s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
   logic [3:0] s_ray = '0, s_grp = '0;
   logic [15:0] s_red = '0, s_green = '0, s_blue = '0, s_alpha = '0;
   logic px_valid, term_req;
   logic [3:0] px_ray, px_grp, term_grp;
   logic [15:0] px_red, px_green, px_blue, px_alpha;

   always #10 clk = ~clk;

   fb_compositor u0 (
      .clk(clk), .rst_n(rst_n), .mip_en(mip_en), .op_thresh(op_thresh),
      .s_valid(s_valid), .s_ray(s_ray), .s_first(s_first), .s_last(s_last), .s_grp(s_grp),
      .s_red(s_red), .s_green(s_green), .s_blue(s_blue), .s_alpha(s_alpha),
      .px_valid(px_valid), .px_ray(px_ray), .px_grp(px_grp),
      .px_red(px_red), .px_green(px_green), .px_blue(px_blue), .px_alpha(px_alpha),
      .term_req(term_req), .term_grp(term_grp)
   );

   int tests = 0;
   int fails = 0;
   bit done = 0;

   int unsigned acc [NR][4];
   int          cnt [NR];
   bit [NR-1:0] flags = '0;
   bit          sent = 0;
   int          tg = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int unsigned fm(input int unsigned x, input int unsigned y);
      longint unsigned p;
      p = longint'(x) * longint'(y);
      return int'(p >> CW);
   endfunction

   function automatic int unsigned sat(input int unsigned v);
      return (v > FS) ? FS : v;
   endfunction

   task automatic step(input bit v, input int ray, input bit f, input bit l, input int g,
                       input int unsigned r, input int unsigned gg,
                       input int unsigned b, input int unsigned a);
      int unsigned sm [4];
      int unsigned bs [4];
      int unsigned nw [4];
      bit e_pv;
      bit e_term;
      string ptag;
      sm[0] = r; sm[1] = gg; sm[2] = b; sm[3] = a;
      s_valid = v; s_ray = 4'(ray); s_first = f; s_last = l; s_grp = 4'(g);
      s_red = 16'(r); s_green = 16'(gg); s_blue = 16'(b); s_alpha = 16'(a);
      e_pv = 0; e_term = 0; ptag = "R2";
      for (int c = 0; c < 4; c++) nw[c] = 0;
      if (v && ray < NR) begin
         if (f && g != tg) begin flags = '0; sent = 0; tg = g; end
         for (int c = 0; c < 4; c++) bs[c] = f ? 0 : acc[ray][c];
         for (int c = 0; c < 4; c++) begin
            if (mip_en) nw[c] = (sm[c] > bs[c]) ? sm[c] : bs[c];
            else if (c == 3) nw[c] = sat(bs[3] + fm(a, FS - bs[3]));
            else nw[c] = sat(bs[c] + fm(fm(sm[c], a), FS - bs[3]));
         end
         for (int c = 0; c < 4; c++) acc[ray][c] = nw[c];
         cnt[ray] = f ? 1 : cnt[ray] + 1;
         flags[ray] = (nw[3] >= int'(op_thresh));
         e_term = (&flags) && !sent && (g == tg);
         if (e_term) sent = 1;
         e_pv = l;
         ptag = mip_en ? "R3" : (cnt[ray] == 1) ? "R1" : sent ? "R8" : "R2";
      end
      @(posedge clk);
      @(negedge clk);
      chk(px_valid == e_pv, (v && ray >= NR) ? "R9" : "R5", "px_valid", px_valid, e_pv);
      if (e_pv && px_valid) begin
         chk(px_red == nw[0], ptag, "red", px_red, nw[0]);
         chk(px_green == nw[1], ptag, "green", px_green, nw[1]);
         chk(px_blue == nw[2], ptag, "blue", px_blue, nw[2]);
         chk(px_alpha == nw[3], ptag, "alpha", px_alpha, nw[3]);
         chk(px_ray == 4'(ray), "R4", "px_ray", px_ray, ray);
         chk(px_grp == 4'(g), "R4", "px_grp", px_grp, g);
      end
      chk(term_req == e_term, e_term ? "R6" : "R7", "term_req", term_req, e_term);
      if (e_term && term_req) chk(term_grp == 4'(g), "R6", "term_grp", term_grp, g);
      s_valid = 0;
   endtask

   task automatic group(input int g, input int len, input int unsigned amin, input int unsigned amax,
                        input bit noise);
      for (int k = 0; k < len; k++) begin
         for (int ray = 0; ray < NR; ray++) begin
            int unsigned a;
            a = amin + ($urandom % (amax - amin + 1));
            if (noise && ($urandom % 8) == 0) step(0, 0, 0, 1, g, 0, 0, 0, 0);
            if (noise && ($urandom % 16) == 0)
               step(1, NR + int'($urandom % 7), ($urandom % 2) == 1, 1, g,
                    $urandom % 65536, $urandom % 65536, $urandom % 65536, $urandom % 65536);
            step(1, ray, k == 0, k == len - 1, g,
                 $urandom % 65536, $urandom % 65536, $urandom % 65536, a);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NR; i++) begin
         cnt[i] = 0;
         for (int c = 0; c < 4; c++) acc[i][c] = 0;
      end
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(px_valid == 0, "R10", "px_valid", px_valid, 0);
      chk(term_req == 0, "R10", "term_req", term_req, 0);
      chk(px_alpha == 0, "R10", "px_alpha", px_alpha, 0);
      rst_n = 1;
      @(negedge clk);
      // R10: a non-first sample blends onto the cleared accumulator
      op_thresh = 16'hFFFF;
      step(1, 4, 0, 1, 0, 40000, 30000, 20000, 32768);
      // R1: single-sample rays on top of stale data
      group(1, 1, 30000, 65535, 0);
      group(1, 1, 1000, 5000, 0);
      // R6/R7/R8: opaque group, termination after round one, then more rounds
      op_thresh = 16'h8000;
      group(2, 4, 65535, 65535, 0);
      // R9: out-of-range ray between rounds
      step(1, 12, 1, 1, 2, 65535, 65535, 65535, 65535);
      step(1, 15, 0, 1, 5, 1, 2, 3, 4);
      // R7: back-to-back groups with zero threshold re-arm
      op_thresh = 16'h0000;
      group(3, 2, 0, 100, 0);
      group(4, 2, 0, 100, 0);
      // R7: same id again does not re-arm
      group(4, 1, 0, 100, 0);
      // R3: max-intensity group
      mip_en = 1;
      op_thresh = 16'hC000;
      group(5, 3, 0, 65535, 0);
      mip_en = 0;
      // R4/R5: random groups with noise
      for (int n = 0; n < 60; n++) begin
         mip_en = (($urandom % 4) == 0);
         op_thresh = 16'($urandom % 65536);
         group(6 + (n % 10), 1 + int'($urandom % 5), 0, ($urandom % 2) ? 65535 : 8000, 1);
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule